// File: doc/BRIEF.md
# Transmit Clock Activity Mode Selector

This block decides how an E1 line transmitter runs by watching two clocks instead of reading configuration bits. A fast, free-running monitor clock oversamples the transmit data clock (nominally 2.048 MHz, ±50 ppm) and the master timing clock. Each input's toggling is timed. A clock that shows no edge for a programmable window, 10 µs by default, counts as stuck. The stuck or toggling state of the two clocks selects one of five operating modes.

The block drives the positive and negative rails for the line driver and a driver output-enable. It can pass RZ rail data straight through. It can re-time NRZ rail data, sampled on a selectable transmit clock edge, into pulses whose width comes from either the master clock or the transmit clock duty cycle. It can also generate an alternating-polarity all-ones pattern timed by the master clock. A transmitter-off input and a long active-low reset both force the output off.

Top module: `tx_clk_mode_mon`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `mode` is 0 (off), `drv_oe` is 0 and both line rails are 0.
- R2: An input counts as stuck once no edge has been seen on it for STUCK_CYC monitor cycles. Any edge clears the stuck state. After reset every watched input starts out stuck.
- R3: While the transmit clock is stuck high, `mode` is 4 (all-ones) and `drv_oe` is 1.
- R4: In all-ones mode, one mark is sent per master clock period, lasting the master clock high phase. Marks alternate between the rails, and the first mark after entering the mode is on `line_p`. The two rails are never high together.
- R5: While the transmit clock is stuck low and no rail input has been active for STUCK_CYC cycles, `mode` is 0 and `drv_oe` is 0.
- R6: While the transmit clock is stuck low and the rails are active, `mode` is 3 (RZ). Each line rail copies its input rail three monitor cycles later. When both input rails are high at once, both outputs are 0.
- R7: While the transmit clock toggles and the master clock is stuck, `mode` is 2 (NRZ). A line rail is high only while the transmit clock is high and the sampled bit for that rail is 1.
- R8: While both clocks toggle, `mode` is 1 (normal). Each master clock rising edge launches the sampled bits onto the rails, and each falling edge clears them.
- R9: `edge_sel` = 1 samples the rail inputs on transmit clock rising edges. `edge_sel` = 0 samples them on falling edges.
- R10: In the cycle after `tx_off` is high, `mode` is 0 and `drv_oe` is 0, whatever the clock activity.
- R11: Holding `hw_rst_n` low for STUCK_CYC monitor cycles forces `mode` 0 and `drv_oe` 0. A shorter low pulse has no effect on the mode.
- R12: Whenever `drv_oe` is 0, both line rails are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running monitor clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_rst_n | input | 1 | Asynchronous active-low reset request, qualified by duration |
| tx_clk | input | 1 | Transmit data clock, oversampled |
| mst_clk | input | 1 | Master timing clock, oversampled |
| tx_off | input | 1 | Forces the transmitter off |
| edge_sel | input | 1 | Sampling edge: 1 rising, 0 falling |
| rail_p_in | input | 1 | Positive rail data input |
| rail_n_in | input | 1 | Negative rail data input |
| mode | output | 3 | 0 off, 1 normal, 2 NRZ, 3 RZ, 4 all-ones |
| drv_oe | output | 1 | Line driver output-enable |
| line_p | output | 1 | Positive rail to line driver |
| line_n | output | 1 | Negative rail to line driver |

## Verification
Rail outputs in RZ mode are due three monitor cycles after an input change: two synchronizer stages, then the output register. `tx_off` acts on `mode` one cycle later. A change of clock activity settles the mode within STUCK_CYC plus about five cycles. The bench drives inputs on falling edges and samples after at least that latency while holding the inputs steady, so no check lands on a transition. Pulse-width and duty checks count high cycles over a window of whole clock periods, with a tolerance of two cycles for the window edges. The all-ones polarity order is checked by a scoreboard, one queue entry per observed mark.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  typedef enum logic [2:0] {
    M_OFF  = 3'd0,
    M_NORM = 3'd1,
    M_NRZ  = 3'd2,
    M_RZ   = 3'd3,
    M_ONES = 3'd4
  } tx_mode_e;
endpackage

// File: rtl/tcm_sync.sv
module tcm_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tcm_stuck_timer.sv
module tcm_stuck_timer #(
  parameter int   LIMIT = 1250,
  parameter logic START_EXPIRED = 1'b1,
  localparam int  CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic expired
);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= START_EXPIRED ? LIM_V : '0;
    else if (clear)      cnt <= '0;
    else if (cnt != LIM_V) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM_V);

  // R2
  clear_restarts_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> !expired);
  // R2
  stuck_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (expired && !clear) |=> expired);
endmodule

// File: rtl/tx_clk_mode_mon.sv
module tx_clk_mode_mon import tcm_pkg::*; #(
  parameter int STUCK_CYC = 1250,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hw_rst_n,
  input  logic       tx_clk,
  input  logic       mst_clk,
  input  logic       tx_off,
  input  logic       edge_sel,
  input  logic       rail_p_in,
  input  logic       rail_n_in,
  output logic [2:0] mode,
  output logic       drv_oe,
  output logic       line_p,
  output logic       line_n
);
  localparam int NSYNC = 5;
  localparam logic [NSYNC-1:0] SYNC_INIT = 5'b10000;

  logic [NSYNC-1:0] sq;
  logic tx_s, mc_s, rp_s, rn_s, hw_s;
  logic tx_prev, mc_prev;
  logic tx_rise, tx_fall, mc_rise, mc_fall;
  logic tx_stuck, mc_gone, rail_idle, long_rst;
  logic smp, dat_p, dat_n, pol;
  tx_mode_e nm, mode_q;

  tcm_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_INIT)) u_sync (
    .clk(clk), .rst(rst),
    .d({hw_rst_n, rail_n_in, rail_p_in, mst_clk, tx_clk}),
    .q(sq)
  );
  assign {hw_s, rn_s, rp_s, mc_s, tx_s} = sq;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_prev <= 1'b0;
      mc_prev <= 1'b0;
    end else begin
      tx_prev <= tx_s;
      mc_prev <= mc_s;
    end
  end

  assign tx_rise = tx_s & ~tx_prev;
  assign tx_fall = ~tx_s & tx_prev;
  assign mc_rise = mc_s & ~mc_prev;
  assign mc_fall = ~mc_s & mc_prev;

  tcm_stuck_timer #(.LIMIT(STUCK_CYC), .START_EXPIRED(1'b1)) u_tx_tmr (
    .clk(clk), .rst(rst), .clear(tx_rise | tx_fall), .expired(tx_stuck));
  tcm_stuck_timer #(.LIMIT(STUCK_CYC), .START_EXPIRED(1'b1)) u_mc_tmr (
    .clk(clk), .rst(rst), .clear(mc_rise | mc_fall), .expired(mc_gone));
  tcm_stuck_timer #(.LIMIT(STUCK_CYC), .START_EXPIRED(1'b1)) u_rail_tmr (
    .clk(clk), .rst(rst), .clear(rp_s | rn_s), .expired(rail_idle));
  tcm_stuck_timer #(.LIMIT(STUCK_CYC), .START_EXPIRED(1'b0)) u_rst_tmr (
    .clk(clk), .rst(rst), .clear(hw_s), .expired(long_rst));

  always_comb begin
    if (long_rst || tx_off)  nm = M_OFF;
    else if (tx_stuck)       nm = tx_s ? M_ONES : (rail_idle ? M_OFF : M_RZ);
    else if (mc_gone)        nm = M_NRZ;
    else                     nm = M_NORM;
  end

  assign smp = edge_sel ? tx_rise : tx_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_OFF;
      drv_oe <= 1'b0;
      line_p <= 1'b0;
      line_n <= 1'b0;
      pol    <= 1'b0;
      dat_p  <= 1'b0;
      dat_n  <= 1'b0;
    end else begin
      mode_q <= nm;
      drv_oe <= (nm != M_OFF);
      if (long_rst) begin
        dat_p <= 1'b0;
        dat_n <= 1'b0;
      end else if (smp) begin
        dat_p <= rp_s;
        dat_n <= rn_s;
      end
      if (nm != M_ONES) pol <= 1'b0;
      case (nm)
        M_NORM: begin
          if (mc_rise) begin
            line_p <= dat_p;
            line_n <= dat_n & ~dat_p;
          end else if (mc_fall) begin
            line_p <= 1'b0;
            line_n <= 1'b0;
          end
        end
        M_NRZ: begin
          line_p <= tx_s & dat_p;
          line_n <= tx_s & dat_n & ~dat_p;
        end
        M_RZ: begin
          line_p <= rp_s & ~rn_s;
          line_n <= rn_s & ~rp_s;
        end
        M_ONES: begin
          if (mc_rise) begin
            line_p <= ~pol;
            line_n <= pol;
            pol    <= ~pol;
          end else if (mc_fall) begin
            line_p <= 1'b0;
            line_n <= 1'b0;
          end
        end
        default: begin
          line_p <= 1'b0;
          line_n <= 1'b0;
        end
      endcase
    end
  end

  assign mode = mode_q;

  // R12
  oe_gates_rails_chk: assert property (@(posedge clk) disable iff (rst)
    !drv_oe |-> (!line_p && !line_n));
  // R4
  rails_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(line_p && line_n));
  // R10
  tx_off_forces_chk: assert property (@(posedge clk) disable iff (rst)
    tx_off |=> (mode_q == M_OFF && !drv_oe));
  // R11
  long_rst_forces_chk: assert property (@(posedge clk) disable iff (rst)
    long_rst |=> (mode_q == M_OFF && !drv_oe));
endmodule

// File: tb/test_tx_clk_mode_mon.sv
module test_tx_clk_mode_mon;
  localparam int LIM = 64;
  localparam int MH  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hw_rst_n = 1'b1, tx_clk = 1'b0, mst_clk = 1'b0, tx_off = 1'b0;
  logic edge_sel = 1'b1, rail_p_in = 1'b0, rail_n_in = 1'b0;
  logic [2:0] mode;
  logic drv_oe, line_p, line_n;

  int n_chk = 0, n_err = 0;
  bit tx_run = 0, tx_hold = 0, rise_pat = 0, mc_run = 0, mon_en = 0, done = 0;
  int tx_hi = 8, tx_lo = 8;
  int pulse_cnt = 0;
  bit exp_q[$];
  logic pp = 1'b0, pn = 1'b0;

  always #4 clk = ~clk;

  tx_clk_mode_mon #(.STUCK_CYC(LIM)) i_tx_clk_mode_mon (
    .clk(clk), .rst(rst), .hw_rst_n(hw_rst_n), .tx_clk(tx_clk), .mst_clk(mst_clk),
    .tx_off(tx_off), .edge_sel(edge_sel), .rail_p_in(rail_p_in), .rail_n_in(rail_n_in),
    .mode(mode), .drv_oe(drv_oe), .line_p(line_p), .line_n(line_n));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, int act, int lo, int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_hi(int n, output int np, output int nn);
    np = 0; nn = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (line_p) np++;
      if (line_n) nn++;
    end
  endtask

  task automatic push_ones(int n);
    for (int i = 0; i < n; i++) exp_q.push_back(i % 2 == 0);
  endtask

  // transmit clock generator
  initial begin
    forever begin
      if (tx_run) begin
        repeat (tx_lo - 1) @(negedge clk);
        if (rise_pat) rail_p_in = 1'b1;
        @(negedge clk);
        tx_clk = 1'b1;
        repeat (2) @(negedge clk);
        if (rise_pat) rail_p_in = 1'b0;
        repeat (tx_hi - 2) @(negedge clk);
        tx_clk = 1'b0;
      end else begin
        tx_clk = tx_hold;
        @(negedge clk);
      end
    end
  end

  // master clock generator
  initial begin
    forever begin
      if (mc_run) begin
        mst_clk = ~mst_clk;
        repeat (MH) @(negedge clk);
      end else begin
        mst_clk = 1'b0;
        @(negedge clk);
      end
    end
  end

  // scoreboard monitor for all-ones polarity
  always @(negedge clk) begin
    if ((line_p && !pp) || (line_n && !pn)) pulse_cnt++;
    if (mon_en && exp_q.size() > 0) begin
      if (line_p && !pp) chk("R4 mark polarity", 1, int'(exp_q.pop_front()));
      else if (line_n && !pn) chk("R4 mark polarity", 0, int'(exp_q.pop_front()));
    end
    pp = line_p;
    pn = line_n;
  end

  initial begin
    int np, nn, c0;
    wait_n(4);
    chk("R1 mode in reset", int'(mode), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mode after reset", int'(mode), 0);
    chk("R1 oe after reset", int'(drv_oe), 0);
    chk("R1 rails after reset", int'({line_p, line_n}), 0);

    wait_n(LIM + 8);
    chk("R5 idle low clock off", int'(mode), 0);
    chk("R5 idle oe", int'(drv_oe), 0);

    tx_run = 1; mc_run = 1;
    wait_n(LIM + 10);
    chk("R8 normal mode", int'(mode), 1);
    chk("R2 toggling not stuck oe", int'(drv_oe), 1);
    rail_p_in = 1'b1;
    wait_n(40);
    count_hi(64, np, nn);
    chk_rng("R8 pulse width from master clock", np, 30, 34);
    chk("R8 negative rail quiet", nn, 0);

    hw_rst_n = 1'b0; wait_n(5); hw_rst_n = 1'b1; wait_n(4);
    chk("R11 short reset ignored", int'(mode), 1);
    hw_rst_n = 1'b0; wait_n(LIM + 8);
    chk("R11 long reset mode", int'(mode), 0);
    chk("R11 long reset oe", int'(drv_oe), 0);
    hw_rst_n = 1'b1; wait_n(10);
    chk("R11 recovery", int'(mode), 1);

    tx_off = 1'b1; wait_n(2);
    chk("R10 tx_off mode", int'(mode), 0);
    chk("R10 tx_off oe", int'(drv_oe), 0);
    chk("R12 rails off with oe low", int'({line_p, line_n}), 0);
    tx_off = 1'b0; wait_n(4);
    chk("R10 tx_off release", int'(mode), 1);

    mc_run = 0;
    wait_n(LIM + 12);
    chk("R7 NRZ mode", int'(mode), 2);
    tx_hi = 12; tx_lo = 4; wait_n(40);
    count_hi(64, np, nn);
    chk_rng("R7 width follows duty 12/16", np, 46, 50);
    tx_hi = 4; tx_lo = 12; wait_n(40);
    count_hi(64, np, nn);
    chk_rng("R7 width follows duty 4/16", np, 14, 18);

    tx_hi = 8; tx_lo = 8; rail_p_in = 1'b0; rise_pat = 1; edge_sel = 1'b1;
    wait_n(40);
    count_hi(64, np, nn);
    chk_rng("R9 rising edge sampling", np, 24, 40);
    edge_sel = 1'b0; wait_n(40);
    count_hi(64, np, nn);
    chk("R9 falling edge sampling", np, 0);
    rise_pat = 0; edge_sel = 1'b1; rail_p_in = 1'b0;

    mc_run = 1; wait_n(LIM + 12);
    chk("R8 normal again", int'(mode), 1);
    push_ones(6);
    mon_en = 1;
    tx_run = 0; tx_hold = 1;
    wait_n(LIM + 12);
    chk("R3 all-ones mode", int'(mode), 4);
    chk("R3 all-ones oe", int'(drv_oe), 1);
    for (int i = 0; i < 200 && exp_q.size() > 0; i++) @(negedge clk);
    chk("R4 all expected marks seen", exp_q.size(), 0);
    mon_en = 0;
    c0 = pulse_cnt;
    wait_n(64);
    chk_rng("R4 one mark per master period", pulse_cnt - c0, 7, 9);

    tx_hold = 0;
    wait_n(LIM + 12);
    chk("R5 held low no data", int'(mode), 0);
    rail_p_in = 1'b1; wait_n(6);
    chk("R6 RZ mode", int'(mode), 3);
    chk("R6 positive passes", int'({line_p, line_n}), 2);
    rail_p_in = 1'b0; rail_n_in = 1'b1; wait_n(3);
    chk("R6 negative passes", int'({line_p, line_n}), 1);
    rail_p_in = 1'b1; wait_n(4);
    chk("R6 both high rejected", int'({line_p, line_n}), 0);
    rail_p_in = 1'b0; rail_n_in = 1'b0; wait_n(4);
    chk("R6 rails released", int'({line_p, line_n}), 0);
    wait_n(LIM + 8);
    chk("R5 data stopped", int'(mode), 0);
    chk("R12 rails off", int'({line_p, line_n}), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule